// File: doc/BRIEF.md
# Crosspoint Connection Matrix Controller

This block holds the connection state of a 16-row by 8-column switch matrix, one bit per crosspoint, and updates it one switch at a time. A write names a row through a 4-bit row code, names a column through a 3-bit column code, and gives the new switch value on a data line. The write happens while a strobe and a chip-select input are both high. A level-sensitive clear input opens every switch. All control inputs are taken to be synchronous to the block clock.

The row code is not binary. Codes 0110 and 0111 reach physical rows 12 and 13. Codes 1000 to 1101 reach rows 6 to 11. All other codes reach the row of the same number. The column code is plain binary. The whole matrix state is brought out as a read-only vector. An optional digital routing path drives each column output with the OR of the row inputs that are currently connected to that column.

Several copies can be tiled into a larger matrix. Each copy gets its own chip select, and all copies share the address, data and strobe lines.

Top module: `xbar_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every bit of `conn_state` is 0 (all switches open).
- R2: The row code maps to physical rows as follows. 0000 to 0101 map to rows 0 to 5. 0110 maps to row 12 and 0111 maps to row 13. 1000 to 1101 map to rows 6 to 11. 1110 maps to row 14 and 1111 maps to row 15.
- R3: The column code selects column 0 to 7 in binary order.
- R4: A write changes only the single bit at the addressed row and column. Data 1 closes the switch (bit = 1) and data 0 opens it (bit = 0).
- R5: When `strobe` is low at a rising clock edge, `conn_state` does not change at that edge.
- R6: When `chip_sel` is low at a rising clock edge, `conn_state` does not change at that edge.
- R7: While `strobe` and `chip_sel` are both high, the addressed bit takes the value of `data_in` at each rising edge. After `strobe` falls, the bit keeps the value it had at the last edge where `strobe` was high. A strobe that is high for a single edge still writes.
- R8: A high `clear_all` at a rising edge sets all 128 bits to 0 at that edge. This holds even if a write is requested in the same cycle.
- R9: Any number and any combination of switches can be closed at once, and each switch holds its value on its own.
- R10: `y_out[j]` is the OR, over all rows r, of (switch (r,j) closed AND `x_in[r]`). It is combinational from `x_in` and the stored state.
- R11: Switch (r,c) appears in `conn_state` at bit r*8+c, where r is the physical row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| row_addr | input | 4 | Row code of the switch to write |
| col_addr | input | 3 | Column code of the switch to write |
| data_in | input | 1 | New switch value: 1 closes, 0 opens |
| strobe | input | 1 | Write enable, active high |
| chip_sel | input | 1 | Device select, active high, gates the strobe |
| clear_all | input | 1 | Opens every switch while high |
| x_in | input | 16 | Row inputs for the digital routing path |
| conn_state | output | 128 | Switch states, row-major by physical row |
| y_out | output | 8 | Routed column outputs |

## Verification
A wrong decode or a stray write shows up as a bad bit in `conn_state` on the cycle right after the offending edge. Because the state is exported, every such error is caught one edge after it happens. It does not wait for a later read. Row-code errors appear as a bit at the wrong row offset, since codes 0110, 0111 and 1000 land far from their binary position. Routing errors show up on `y_out` in the same cycle that `x_in` is applied against a known state.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int ROWS  = 16;
  localparam int COLS  = 8;
  localparam int RA_W  = $clog2(ROWS);
  localparam int CA_W  = $clog2(COLS);
  localparam int NSW   = ROWS * COLS;
  localparam int IDX_W = $clog2(NSW);

  // Row code to physical row: codes 6..7 jump up to rows 12..13,
  // codes 8..13 slide down to rows 6..11, the rest map straight through.
  function automatic logic [RA_W-1:0] phys_row(input logic [RA_W-1:0] code);
    if (code >= RA_W'(6) && code <= RA_W'(7))
      return code + RA_W'(6);
    else if (code >= RA_W'(8) && code <= RA_W'(13))
      return code - RA_W'(2);
    else
      return code;
  endfunction

  function automatic logic [IDX_W-1:0] flat_idx(input logic [RA_W-1:0] row,
                                                input logic [CA_W-1:0] col);
    return IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);
  endfunction
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
  import xbar_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RA_W-1:0] row_addr,
  input  logic [CA_W-1:0] col_addr,
  output logic [RA_W-1:0] wr_row,
  output logic [CA_W-1:0] wr_col,
  output logic [ROWS-1:0] row_sel,
  output logic [COLS-1:0] col_sel
);
  assign wr_row = phys_row(row_addr);
  assign wr_col = col_addr;

  for (genvar r = 0; r < ROWS; r++) begin : g_rsel
    assign row_sel[r] = (wr_row == RA_W'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_csel
    assign col_sel[c] = (wr_col == CA_W'(c));
  end

  // R2: exactly one row line is selected by any code
  p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_sel) == 1);
  // R2: the out-of-order codes land on their rows
  p_code6_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr == 4'b0110) |-> row_sel[12]);
  p_code8_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_addr == 4'b1000) |-> row_sel[6]);
  // R3: one column line selected
  p_col_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(col_sel) == 1);
endmodule

// File: rtl/xbar_state.sv
module xbar_state
  import xbar_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_data,
  input  logic            clr,
  input  logic [RA_W-1:0] wr_row,
  input  logic [CA_W-1:0] wr_col,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_sel,
  output logic [NSW-1:0]  state
);
  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = flat_idx(wr_row, wr_col);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          state[r*COLS+c] <= 1'b0;
        else if (clr)
          state[r*COLS+c] <= 1'b0;
        else if (wr_en && row_sel[r] && col_sel[c])
          state[r*COLS+c] <= wr_data;
      end
    end
  end

  // R8: clear wins and empties the array
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state == '0));
  // R5 / R6: no enabled write means no change
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(state));
  // R4: a write touches at most one bit
  p_onebit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> ($countones(state ^ $past(state)) <= 1));
  // R7: addressed bit follows data while enabled
  p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (state[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSW-1:0]  state,
  input  logic [ROWS-1:0] x_in,
  output logic [COLS-1:0] y_out
);
  for (genvar j = 0; j < COLS; j++) begin : g_colout
    always_comb begin
      y_out[j] = 1'b0;
      for (int r = 0; r < ROWS; r++)
        y_out[j] = y_out[j] | (state[r*COLS+j] & x_in[r]);
    end
  end

  // R10: no driven row or no connection gives quiet columns
  p_quiet_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (x_in == '0) |-> (y_out == '0));
  p_quiet_st_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == '0) |-> (y_out == '0));
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           row_addr,
  input  logic [2:0]           col_addr,
  input  logic                 data_in,
  input  logic                 strobe,
  input  logic                 chip_sel,
  input  logic                 clear_all,
  input  logic [15:0]          x_in,
  output logic [127:0]         conn_state,
  output logic [7:0]           y_out
);
  logic [RA_W-1:0] wr_row;
  logic [CA_W-1:0] wr_col;
  logic [ROWS-1:0] row_sel;
  logic [COLS-1:0] col_sel;
  logic            wr_en;

  assign wr_en = strobe & chip_sel;

  xbar_decode u_dec (
    .clk(clk), .rst_n(rst_n), .row_addr(row_addr), .col_addr(col_addr),
    .wr_row(wr_row), .wr_col(wr_col), .row_sel(row_sel), .col_sel(col_sel)
  );

  xbar_state u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(data_in), .clr(clear_all),
    .wr_row(wr_row), .wr_col(wr_col), .row_sel(row_sel), .col_sel(col_sel),
    .state(conn_state)
  );

  xbar_route u_rt (
    .clk(clk), .rst_n(rst_n), .state(conn_state), .x_in(x_in), .y_out(y_out)
  );

  // R6: deselected device keeps its array
  p_cs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel && !clear_all) |=> $stable(conn_state));
  // R1: state is empty right after reset release
  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (conn_state == '0));
endmodule

// File: tb/tb_xbar_ctrl.sv
`timescale 1ns/1ps
module tb_xbar_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] row_addr = '0;
  logic [2:0] col_addr = '0;
  logic data_in = 1'b0, strobe = 1'b0, chip_sel = 1'b0, clear_all = 1'b0;
  logic [15:0] x_in = '0;
  logic [127:0] conn_state;
  logic [7:0] y_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [127:0] model = '0;

  localparam int CODE2ROW [16] = '{0,1,2,3,4,5,12,13,6,7,8,9,10,11,14,15};

  // vector: {clear, cs, strobe, data, row code[3:0], col[2:0]}
  localparam logic [10:0] VEC [14] = '{
    {1'b0,1'b1,1'b1,1'b1,4'b0110,3'd5},
    {1'b0,1'b1,1'b1,1'b1,4'b0111,3'd0},
    {1'b0,1'b1,1'b1,1'b1,4'b1000,3'd7},
    {1'b0,1'b1,1'b1,1'b1,4'b1101,3'd3},
    {1'b0,1'b1,1'b1,1'b1,4'b0000,3'd0},
    {1'b0,1'b1,1'b1,1'b1,4'b1111,3'd7},
    {1'b0,1'b0,1'b1,1'b1,4'b0011,3'd2},
    {1'b0,1'b1,1'b0,1'b1,4'b0100,3'd4},
    {1'b0,1'b1,1'b1,1'b0,4'b0110,3'd5},
    {1'b0,1'b1,1'b1,1'b1,4'b0101,3'd6},
    {1'b0,1'b1,1'b1,1'b1,4'b1110,3'd1},
    {1'b0,1'b0,1'b1,1'b0,4'b1000,3'd7},
    {1'b0,1'b1,1'b1,1'b1,4'b1001,3'd2},
    {1'b0,1'b1,1'b1,1'b0,4'b1001,3'd2}
  };

  xbar_ctrl dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_y(input logic [127:0] st, input logic [15:0] x);
    logic [7:0] y = '0;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 16; r++)
        if (x[r] && st[r*8+c]) y[c] = 1'b1;
    return y;
  endfunction

  // drive on falling edge, update model at rising edge, compare 1 ns later
  task automatic cycle(input logic clr, input logic cs, input logic stb,
                       input logic d, input logic [3:0] ra, input logic [2:0] ca);
    @(negedge clk);
    clear_all = clr; chip_sel = cs; strobe = stb; data_in = d;
    row_addr = ra; col_addr = ca;
    @(posedge clk);
    if (clr) model = '0;
    else if (cs && stb) model[CODE2ROW[ra]*8 + ca] = d;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #7;
    check("R1 reset state", conn_state, '0);
    check("R1 reset y", {120'b0, y_out}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", conn_state, '0);

    // table walk: R2 R3 R4 R5 R6 R7
    foreach (VEC[i]) begin
      cycle(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:3], VEC[i][2:0]);
      check($sformatf("R2/R4/R5/R6 vec %0d", i), conn_state, model);
    end
    // R11 / R2: code 0111 col 0 -> bit 104, code 1000 col 7 -> bit 55
    check("R11 bit 104", {127'b0, conn_state[104]}, 128'd1);
    check("R11 bit 55", {127'b0, conn_state[55]}, 128'd1);
    // R4 open: code 0110 col 5 (bit 101) was opened by vector 8
    check("R4 opened bit 101", {127'b0, conn_state[101]}, 128'd0);

    // R7: multi-cycle strobe, data toggles; last high edge value stays
    cycle(0, 1, 1, 1, 4'b1010, 3'd4);
    cycle(0, 1, 1, 0, 4'b1010, 3'd4);
    cycle(0, 1, 1, 1, 4'b1010, 3'd4);
    cycle(0, 1, 0, 0, 4'b1010, 3'd4);
    check("R7 latched at strobe fall", {127'b0, conn_state[8*8+4]}, 128'd1);
    cycle(0, 1, 0, 0, 4'b1010, 3'd4);
    check("R7 hold", conn_state, model);

    // R9 R3: random writes, many bits closed together
    for (int k = 0; k < 60; k++)
      cycle(0, 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 4) != 0),
            1'($urandom_range(0, 3) != 0), 4'($urandom), 3'($urandom));
    check("R9 random state", conn_state, model);

    // R10 routing under several patterns
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      x_in = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0001 : 16'($urandom);
      #1;
      check($sformatf("R10 route %0d", k), {120'b0, y_out}, {120'b0, exp_y(model, x_in)});
    end

    // R8: clear with simultaneous write, mid sequence
    cycle(1, 1, 1, 1, 4'b0010, 3'd1);
    check("R8 clear beats write", conn_state, '0);
    cycle(0, 1, 1, 1, 4'b0010, 3'd1);
    check("R8 resume after clear", conn_state, model);
    check("R8 resume bit", {127'b0, conn_state[2*8+1]}, 128'd1);
    @(negedge clk); x_in = 16'h0004; #1;
    check("R10 single route", {120'b0, y_out}, 128'h02);

    // R6 CS low with strobe over several edges
    cycle(0, 0, 1, 1, 4'b1111, 3'd0);
    cycle(0, 0, 1, 0, 4'b0010, 3'd1);
    check("R6 cs low no effect", conn_state, model);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule